// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start-Bit Validation

This block recovers bytes from an asynchronous serial line. The line is idle high. A frame is one low start bit, DATA_BITS data bits sent least significant bit first, and one high stop bit. Timing comes from a one-cycle `sample_tick` enable that pulses OVERSAMPLE times per bit period. The block does not generate this enable.

The line passes through a synchroniser. A falling edge only arms the receiver. The receiver then counts sample ticks and looks at the line again near the centre of the start bit. If the line is high again by then, the edge was a glitch and the receiver goes back to hunting for a new edge. If the start bit holds, each data bit and then the stop bit are sampled every OVERSAMPLE ticks.

A finished byte leaves through a valid/ready output, together with a framing-error flag. The output holds one byte. `out_valid` stays high, and data and flag stay unchanged, until `out_ready` is seen high on a clock edge. If a new byte finishes while the held byte has not been taken, the new byte is dropped and a sticky `overrun` status is raised.

Top module: `uart_rx_top`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0.
- R2: A falling edge on `rx_line` arms the receiver. The line is sampled on the (OVERSAMPLE/2)th tick after the edge. If it is 1 there, no byte is produced and the receiver hunts for the next falling edge.
- R3: Once the start bit is accepted, data bits are sampled every OVERSAMPLE ticks, least significant bit first. The assembled byte appears on `out_data`.
- R4: The stop bit is sampled OVERSAMPLE ticks after the last data bit. `out_ferr` is 0 with the byte when the stop sample is 1, and 1 when it is 0.
- R5: After a stop sample of 0, the receiver waits until the line reads 1 before it re-arms. A line held low does not produce further bytes.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_ferr` keep their values on the next cycle.
- R7: If a byte finishes while the held byte is valid and not accepted in that cycle, the new byte is discarded, the held byte is kept, and `overrun` becomes 1.
- R8: `overrun` stays 1 until a cycle with `status_rd` = 1 clears it. If a new overrun occurs in the same cycle, the overrun wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle enable, OVERSAMPLE pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| out_ready | input | 1 | Downstream can accept the held byte |
| status_rd | input | 1 | One-cycle pulse that clears `overrun` |
| out_valid | output | 1 | Held byte is valid |
| out_data | output | DATA_BITS | Received byte |
| out_ferr | output | 1 | Stop bit of this byte sampled as 0 |
| overrun | output | 1 | Sticky: a byte was dropped because the output was full |

## Verification
Every byte value is sent as a clean frame with the output always ready. Any bit-order, bit-count or sample-phase error shows up as a wrong value.

A short low pulse, shorter than half a bit, tells start-bit validation apart from plain edge triggering. The frame that follows it checks that the receiver re-armed cleanly.

A frame with a low stop bit, followed by a line held low, separates the framing flag from the wait-for-high rule. Two frames sent against a stalled output, then a status read, separate keeping the held byte, dropping the new one, and clearing the sticky overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_HUNT   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_STOP   = 3'd3,
    RX_WAITHI = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign line_s    = chain_q[STAGES-1];
  assign line_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_s,
  input  logic                 line_fall,
  output logic                 push,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_ferr
);
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int IDX_W  = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        RX_HUNT: begin
          cnt_q <= '0;
          if (line_fall) state_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (cnt_q == CNT_MID) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= line_s ? RX_HUNT : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            shreg_q <= {line_s, shreg_q[DATA_BITS-1:1]};
            if (idx_q == IDX_LAST) state_q <= RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            state_q <= line_s ? RX_HUNT : RX_WAITHI;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_WAITHI: if (line_s) state_q <= RX_HUNT;
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign push      = (state_q == RX_STOP) && tick && (cnt_q == CNT_FULL);
  assign push_data = shreg_q;
  assign push_ferr = ~line_s;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [DATA_BITS-1:0] push_data,
  input  logic                 push_ferr,
  input  logic                 ready,
  input  logic                 status_rd,
  output logic                 valid,
  output logic [DATA_BITS-1:0] data,
  output logic                 ferr,
  output logic                 ovr
);
  logic blocked;
  assign blocked = valid & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (status_rd) ovr <= 1'b0;
      if (push) begin
        if (blocked) begin
          ovr <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= push_data;
          ferr  <= push_ferr;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_tick,
  input  logic                 rx_line,
  input  logic                 out_ready,
  input  logic                 status_rd,
  output logic                 out_valid,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_ferr,
  output logic                 overrun
);
  logic                 line_s, line_fall;
  logic                 push, push_ferr;
  logic [DATA_BITS-1:0] push_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line),
    .line_s(line_s), .line_fall(line_fall)
  );

  uart_rx_frame #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .line_s(line_s), .line_fall(line_fall),
    .push(push), .push_data(push_data), .push_ferr(push_ferr)
  );

  uart_rx_hold #(.DATA_BITS(DATA_BITS)) hold_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_ferr(push_ferr), .ready(out_ready), .status_rd(status_rd),
    .valid(out_valid), .data(out_data), .ferr(out_ferr), .ovr(overrun)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_tick,
  input logic                 out_ready,
  input logic                 status_rd,
  input logic                 out_valid,
  input logic [DATA_BITS-1:0] out_data,
  input logic                 out_ferr,
  input logic                 overrun
);
  // R6: a stalled output keeps its byte and flag
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr)));

  // R8: overrun is sticky until a status read
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);

  // R7: overrun only rises when the output was stalled
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(out_valid && !out_ready));

  // R4: a byte completes only on a sample tick
  p_push_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(sample_tick));

  // R1: nothing pending right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && !overrun));
endmodule

bind uart_rx_top uart_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
  .out_ready(out_ready), .status_rd(status_rd), .out_valid(out_valid),
  .out_data(out_data), .out_ferr(out_ferr), .overrun(overrun)
);

// File: tb/uart_rx_top_tb_top.sv
`timescale 1ns/1ps
module uart_rx_top_tb_top;
  localparam int OS       = 16;
  localparam int TICK_DIV = 2;
  localparam int BIT_CLK  = OS * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick;
  logic       rx_line = 1'b1;
  logic       out_ready = 1'b1;
  logic       status_rd = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ferr;
  logic       overrun;

  int n_checks = 0;
  int n_errors = 0;
  int cap_cnt  = 0;
  logic [7:0] cap_data = '0;
  logic       cap_ferr = 1'b0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) sample_tick <= 1'b0;
    else        sample_tick <= ~sample_tick;

  uart_rx_top #(.DATA_BITS(8), .OVERSAMPLE(OS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .out_ready(out_ready), .status_rd(status_rd), .out_valid(out_valid),
    .out_data(out_data), .out_ferr(out_ferr), .overrun(overrun)
  );

  always @(posedge clk)
    if (rst_n && out_valid && out_ready) begin
      cap_cnt  <= cap_cnt + 1;
      cap_data <= out_data;
      cap_ferr <= out_ferr;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int nclk);
    @(negedge clk);
    rx_line = v;
    repeat (nclk - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v);
    hold_line(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold_line(b[i], BIT_CLK);
    hold_line(stop_v, BIT_CLK);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    hold_line(1'b1, 20);

    // R3 R4: every byte value, clean frames
    for (int v = 0; v < 256; v++) begin
      base = cap_cnt;
      send_frame(8'(v), 1'b1);
      hold_line(1'b1, 6);
      chk(cap_cnt == base + 1, "R3 count", cap_cnt, base + 1);
      chk(cap_data == 8'(v), "R3 data", cap_data, v);
      chk(cap_ferr == 1'b0, "R4 ferr clean", cap_ferr, 0);
    end

    // R2: short glitch rejected, then a good frame
    base = cap_cnt;
    hold_line(1'b0, 5 * TICK_DIV);
    hold_line(1'b1, 3 * BIT_CLK);
    chk(cap_cnt == base && !out_valid, "R2 glitch", cap_cnt, base);
    send_frame(8'hA5, 1'b1);
    hold_line(1'b1, 6);
    chk(cap_cnt == base + 1 && cap_data == 8'hA5, "R2 rearm", cap_data, 8'hA5);

    // R4 R5: low stop bit, line held low afterwards
    base = cap_cnt;
    send_frame(8'h3C, 1'b0);
    hold_line(1'b0, 6);
    chk(cap_cnt == base + 1 && cap_data == 8'h3C, "R4 data", cap_data, 8'h3C);
    chk(cap_ferr == 1'b1, "R4 ferr set", cap_ferr, 1);
    hold_line(1'b0, 12 * BIT_CLK);
    chk(cap_cnt == base + 1, "R5 held low", cap_cnt, base + 1);
    hold_line(1'b1, 2 * BIT_CLK);
    send_frame(8'h81, 1'b1);
    hold_line(1'b1, 6);
    chk(cap_cnt == base + 2 && cap_data == 8'h81 && !cap_ferr, "R5 recover",
        cap_data, 8'h81);

    // R6 R7 R8: stalled output
    base = cap_cnt;
    @(negedge clk); out_ready = 1'b0;
    send_frame(8'h11, 1'b1);
    hold_line(1'b1, 6);
    chk(out_valid && out_data == 8'h11, "R6 held", out_data, 8'h11);
    chk(overrun == 1'b0, "R7 no ovr yet", overrun, 0);
    send_frame(8'h22, 1'b1);
    hold_line(1'b1, 6);
    chk(out_valid && out_data == 8'h11, "R7 kept old", out_data, 8'h11);
    chk(overrun == 1'b1, "R7 ovr set", overrun, 1);
    hold_line(1'b1, 10);
    chk(overrun == 1'b1, "R8 sticky", overrun, 1);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk(overrun == 1'b0, "R8 cleared", overrun, 0);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cap_cnt == base + 1 && cap_data == 8'h11, "R6 drained", cap_data, 8'h11);
    chk(out_valid == 1'b0, "R7 dropped byte absent", out_valid, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule